// File: doc/BRIEF.md
# Serial-Entry Sixteen-Bit ALU with Status Flags

This block is an arithmetic/logic unit whose two operands and operation code come in one after another over a single shared input bus. A small sequencer steps through the entry of operand A, operand B and the operation code. Each of these values is taken on a strobe pulse. After the code is taken, the sequencer spends one cycle in a show state. At the end of that cycle it registers the result and four status flags, then returns to wait for the next operand A. The registered result and flags stay unchanged until the next show cycle.

Twelve operations are provided:

- addition and subtraction in two's complement;
- four bitwise functions;
- logical, arithmetic and rotating shifts of A in either direction, by a count taken from B.

Arithmetic results report carry and overflow. Every result reports its sign and whether it is zero. A state output lets the surrounding logic see which value the sequencer expects next.

Top module: `seq_alu`

## Requirements
- R1: While reset is asserted, `state` is 0 (idle), `result` is 0 and `flags` is 4'b0001. One clock edge after reset is released, `state` becomes 1 (waiting for A), whatever the strobe does.
- R2: A strobe in state 1 captures `data_in` as A and moves to state 2. A strobe in state 2 captures B and moves to state 3. A strobe in state 3 captures `data_in[3:0]` as the operation code and moves to state 4 (show). The upper bits of `data_in` are ignored for the code. Without a strobe, states 1 to 3 hold.
- R3: State 4 always moves to state 1 at the next edge, and a strobe there is ignored. `result` and `flags` load at that same edge, so they are valid two edges after the code strobe. They hold their value at every other edge.
- R4: Code 0 gives A+B. Code 1 gives A−B. Carry is the unsigned carry-out for addition and the borrow (A < B unsigned) for subtraction. Overflow is set on a two's-complement signed overflow.
- R5: Code 2 gives A AND B, code 3 gives A OR B, code 4 gives A XOR B, and code 5 gives NOT A.
- R6: The shift count is B[3:0]. Code 6 shifts A left logically. Code 7 shifts A right logically, filling with zeros. Code 8 shifts A left arithmetically, which gives the same result as code 6. Code 9 shifts A right arithmetically, filling with copies of A[15]. A count of 0 returns A.
- R7: Code 10 rotates A left by B[3:0] places and code 11 rotates A right by B[3:0] places. No bits are lost in either rotation.
- R8: Codes 12 to 15 give a result of 0.
- R9: The flag layout is `flags[3]` carry, `flags[2]` overflow, `flags[1]` sign and `flags[0]` zero. Carry and overflow are 0 for all codes other than 0 and 1. Sign equals result bit 15. Zero is set exactly when the result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_in | input | 16 | Shared bus carrying A, then B, then the operation code in bits 3:0 |
| strobe | input | 1 | Capture request for the value on `data_in` |
| result | output | 16 | Registered result |
| flags | output | 4 | Registered {carry, overflow, sign, zero} |
| state | output | 3 | 0 idle, 1 wait A, 2 wait B, 3 wait code, 4 show |

## Verification
Each strobe changes `state` at the very next edge. `result` and `flags` change only at the edge that ends the show cycle, which is the second edge after the code strobe. The bench drives inputs on the falling edge and samples on the following falling edge. It reads the show state at the falling edge right after the code strobe, while the previous result must still be present. It then checks the new result and flags one falling edge later. Idle cycles between strobes confirm that the wait states hold, and a strobe held through the show cycle confirms that it is dropped.

// File: rtl/seq_alu_pkg.sv
package seq_alu_pkg;

   localparam int OP_W = 4;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_GET_A  = 3'd1,
      ST_GET_B  = 3'd2,
      ST_GET_OP = 3'd3,
      ST_SHOW   = 3'd4
   } seq_state_t;

   typedef enum logic [OP_W-1:0] {
      OP_ADD = 4'd0,
      OP_SUB = 4'd1,
      OP_AND = 4'd2,
      OP_OR  = 4'd3,
      OP_XOR = 4'd4,
      OP_NOT = 4'd5,
      OP_SLL = 4'd6,
      OP_SRL = 4'd7,
      OP_SAL = 4'd8,
      OP_SAR = 4'd9,
      OP_ROL = 4'd10,
      OP_ROR = 4'd11
   } alu_op_t;

   typedef enum logic [1:0] {
      SH_LOGIC = 2'd0,
      SH_ARITH = 2'd1,
      SH_ROT   = 2'd2
   } shift_kind_t;

   typedef struct packed {
      logic c;
      logic v;
      logic n;
      logic z;
   } alu_flags_t;

endpackage

// File: rtl/seq_alu_shifter.sv
module seq_alu_shifter
   import seq_alu_pkg::*;
#(
   parameter int WIDTH = 16,
   localparam int CNT_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] din,
   input  logic [CNT_W-1:0] cnt,
   input  logic             dir_left,
   input  shift_kind_t      kind,
   output logic [WIDTH-1:0] dout
);

   if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
      $error("seq_alu_shifter: WIDTH must be a power of two of at least 2");
   end

   logic [WIDTH-1:0] stg [0:CNT_W];
   assign stg[0] = din;

   for (genvar i = 0; i < CNT_W; i++) begin : g_stage
      localparam int S = 1 << i;
      logic [S-1:0]     lfill;
      logic [S-1:0]     rfill;
      logic [WIDTH-1:0] lft;
      logic [WIDTH-1:0] rgt;
      always_comb begin
         lfill = (kind == SH_ROT) ? stg[i][WIDTH-1 -: S] : '0;
         if (kind == SH_ROT)
            rfill = stg[i][S-1:0];
         else if (kind == SH_ARITH)
            rfill = {S{stg[i][WIDTH-1]}};
         else
            rfill = '0;
         lft = {stg[i][WIDTH-1-S:0], lfill};
         rgt = {rfill, stg[i][WIDTH-1:S]};
      end
      assign stg[i+1] = cnt[i] ? (dir_left ? lft : rgt) : stg[i];
   end

   assign dout = stg[CNT_W];

   always_comb begin
      if (kind == SH_ROT) begin
         // R7
         rot_keep_bits_chk: assert ($countones(dout) == $countones(din));
      end
   end

endmodule

// File: rtl/seq_alu_core.sv
module seq_alu_core
   import seq_alu_pkg::*;
#(
   parameter int WIDTH = 16,
   localparam int CNT_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic [OP_W-1:0]  opc,
   output logic [WIDTH-1:0] res,
   output alu_flags_t       flg
);

   logic [WIDTH:0]   sum_x;
   logic [WIDTH:0]   dif_x;
   logic [WIDTH-1:0] sh_out;
   logic             sh_left;
   shift_kind_t      sh_kind;

   assign sum_x = {1'b0, opa} + {1'b0, opb};
   assign dif_x = {1'b0, opa} - {1'b0, opb};

   always_comb begin
      sh_left = (opc == OP_SLL) || (opc == OP_SAL) || (opc == OP_ROL);
      if (opc == OP_ROL || opc == OP_ROR)
         sh_kind = SH_ROT;
      else if (opc == OP_SAR)
         sh_kind = SH_ARITH;
      else
         sh_kind = SH_LOGIC;
   end

   seq_alu_shifter #(.WIDTH(WIDTH)) u_shift (
      .din      (opa),
      .cnt      (opb[CNT_W-1:0]),
      .dir_left (sh_left),
      .kind     (sh_kind),
      .dout     (sh_out)
   );

   always_comb begin
      res   = '0;
      flg.c = 1'b0;
      flg.v = 1'b0;
      case (opc)
         OP_ADD: begin
            res   = sum_x[WIDTH-1:0];
            flg.c = sum_x[WIDTH];
            flg.v = (opa[WIDTH-1] == opb[WIDTH-1]) && (res[WIDTH-1] != opa[WIDTH-1]);
         end
         OP_SUB: begin
            res   = dif_x[WIDTH-1:0];
            flg.c = dif_x[WIDTH];
            flg.v = (opa[WIDTH-1] != opb[WIDTH-1]) && (res[WIDTH-1] != opa[WIDTH-1]);
         end
         OP_AND: res = opa & opb;
         OP_OR:  res = opa | opb;
         OP_XOR: res = opa ^ opb;
         OP_NOT: res = ~opa;
         OP_SLL, OP_SRL, OP_SAL, OP_SAR, OP_ROL, OP_ROR: res = sh_out;
         default: res = '0;
      endcase
      flg.n = res[WIDTH-1];
      flg.z = (res == '0);
   end

endmodule

// File: rtl/seq_alu_ctrl.sv
module seq_alu_ctrl
   import seq_alu_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   input  logic             strobe,
   output seq_state_t       state,
   output logic [WIDTH-1:0] opa,
   output logic [WIDTH-1:0] opb,
   output logic [OP_W-1:0]  opc,
   output logic             commit
);

   if (WIDTH < OP_W) begin : g_bad_width
      $error("seq_alu_ctrl: WIDTH must be at least the opcode width");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         opa   <= '0;
         opb   <= '0;
         opc   <= '0;
      end else begin
         case (state)
            ST_IDLE: state <= ST_GET_A;
            ST_GET_A: if (strobe) begin
               opa   <= din;
               state <= ST_GET_B;
            end
            ST_GET_B: if (strobe) begin
               opb   <= din;
               state <= ST_GET_OP;
            end
            ST_GET_OP: if (strobe) begin
               opc   <= din[OP_W-1:0];
               state <= ST_SHOW;
            end
            ST_SHOW: state <= ST_GET_A;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign commit = (state == ST_SHOW);

   // R1
   idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |=> (state == ST_GET_A));

   // R2
   take_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_GET_A && strobe) |=> (state == ST_GET_B && opa == $past(din)));

   // R2
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_GET_A || state == ST_GET_B || state == ST_GET_OP) && !strobe)
      |=> $stable(state));

   // R3
   show_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SHOW) |=> (state == ST_GET_A && $stable(opa)));

endmodule

// File: rtl/seq_alu.sv
module seq_alu
   import seq_alu_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] data_in,
   input  logic             strobe,
   output logic [WIDTH-1:0] result,
   output logic [3:0]       flags,
   output logic [2:0]       state
);

   if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
      $error("seq_alu: WIDTH must be a power of two of at least 2");
   end

   seq_state_t       st;
   logic [WIDTH-1:0] opa;
   logic [WIDTH-1:0] opb;
   logic [OP_W-1:0]  opc;
   logic             commit;
   logic [WIDTH-1:0] core_res;
   alu_flags_t       core_flg;
   alu_flags_t       flg_q;

   seq_alu_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (data_in),
      .strobe (strobe),
      .state  (st),
      .opa    (opa),
      .opb    (opb),
      .opc    (opc),
      .commit (commit)
   );

   seq_alu_core #(.WIDTH(WIDTH)) u_core (
      .opa (opa),
      .opb (opb),
      .opc (opc),
      .res (core_res),
      .flg (core_flg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result <= '0;
         flg_q  <= '{c: 1'b0, v: 1'b0, n: 1'b0, z: 1'b1};
      end else if (commit) begin
         result <= core_res;
         flg_q  <= core_flg;
      end
   end

   assign flags = flg_q;
   assign state = st;

   // R3
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(result) && $stable(flags)));

   // R9
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags[0] == (result == '0));

   // R9
   sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags[1] == result[WIDTH-1]);

   // R9
   cv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && opc != OP_ADD && opc != OP_SUB) |=> (flags[3:2] == 2'b00));

endmodule

// File: tb/seq_alu_tb.sv
`timescale 1ns/1ps
module seq_alu_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] data_in = '0;
   logic        strobe = 1'b0;
   logic [15:0] result;
   logic [3:0]  flags;
   logic [2:0]  state;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   seq_alu u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .data_in (data_in),
      .strobe  (strobe),
      .result  (result),
      .flags   (flags),
      .state   (state)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // expected {c,v,n,z,result} from the requirement text
   function automatic logic [19:0] model(input logic [15:0] a, input logic [15:0] b,
                                         input logic [3:0] op);
      logic [16:0] t;
      logic [15:0] r;
      logic c;
      logic v;
      int n;
      n = int'(b[3:0]);
      c = 1'b0;
      v = 1'b0;
      r = '0;
      case (op)
         4'd0: begin
            t = {1'b0, a} + {1'b0, b};
            r = t[15:0];
            c = t[16];
            v = (a[15] == b[15]) && (r[15] != a[15]);
         end
         4'd1: begin
            r = a - b;
            c = (a < b);
            v = (a[15] != b[15]) && (r[15] != a[15]);
         end
         4'd2: r = a & b;
         4'd3: r = a | b;
         4'd4: r = a ^ b;
         4'd5: r = ~a;
         4'd6, 4'd8: r = a << n;
         4'd7: r = a >> n;
         4'd9: r = 16'($signed(a) >>> n);
         4'd10: r = (n == 0) ? a : ((a << n) | (a >> (16 - n)));
         4'd11: r = (n == 0) ? a : ((a >> n) | (a << (16 - n)));
         default: r = '0;
      endcase
      return {c, v, r[15], (r == 16'h0), r};
   endfunction

   task automatic enter(input logic [15:0] v);
      @(negedge clk);
      data_in = v;
      strobe  = 1'b1;
      @(negedge clk);
      strobe  = 1'b0;
   endtask

   // full operation with result timing check (R2, R3)
   task automatic run_op(input string tag, input logic [15:0] a, input logic [15:0] b,
                         input logic [3:0] op);
      logic [15:0] prev;
      logic [19:0] exp;
      prev = result;
      exp  = model(a, b, op);
      check({tag, " R2 start in wait-A"}, 32'(state), 32'd1);
      enter(a);
      check({tag, " R2 wait-B"}, 32'(state), 32'd2);
      enter(b);
      check({tag, " R2 wait-code"}, 32'(state), 32'd3);
      enter({12'hA5C, op});
      check({tag, " R3 show state"}, 32'(state), 32'd4);
      check({tag, " R3 result held in show"}, 32'(result), 32'(prev));
      @(negedge clk);
      check({tag, " R3 back to wait-A"}, 32'(state), 32'd1);
      check({tag, " result"}, 32'(result), 32'(exp[15:0]));
      check({tag, " R9 flags"}, 32'(flags), 32'(exp[19:16]));
   endtask

   task automatic t_reset();
      check("R1 reset state", 32'(state), 32'd0);
      check("R1 reset result", 32'(result), 32'd0);
      check("R1 reset flags", 32'(flags), 32'b0001);
      @(negedge clk);
      rst_n  = 1'b1;
      strobe = 1'b1;
      data_in = 16'hDEAD;
      @(negedge clk);
      strobe = 1'b0;
      check("R1 idle to wait-A", 32'(state), 32'd1);
      @(negedge clk);
      check("R1 strobe in idle ignored", 32'(state), 32'd1);
   endtask

   task automatic t_arith();
      run_op("R4 add 1+2", 16'h0001, 16'h0002, 4'd0);
      check("R4 add 1+2 literal", {12'h0, flags, result}, 32'h0000_0003);
      run_op("R4 add signed ovf", 16'h7FFF, 16'h0001, 4'd0);
      check("R4 ovf flags literal", 32'(flags), 32'b0110);
      run_op("R4 add carry zero", 16'hFFFF, 16'h0001, 4'd0);
      check("R4 carry flags literal", 32'(flags), 32'b1001);
      run_op("R4 sub 5-3", 16'h0005, 16'h0003, 4'd1);
      run_op("R4 sub borrow", 16'h0003, 16'h0005, 4'd1);
      check("R4 borrow flags literal", 32'(flags), 32'b1010);
      run_op("R4 sub signed ovf", 16'h8000, 16'h0001, 4'd1);
      check("R4 sub ovf flags literal", 32'(flags), 32'b0100);
   endtask

   task automatic t_logic();
      run_op("R5 and", 16'hF0F0, 16'h3C3C, 4'd2);
      run_op("R5 or", 16'hF000, 16'h000F, 4'd3);
      run_op("R5 xor", 16'hAAAA, 16'hAAAA, 4'd4);
      run_op("R5 not", 16'h0F0F, 16'h1234, 4'd5);
   endtask

   task automatic t_shift();
      run_op("R6 sll cnt low bits", 16'h8001, 16'h0011, 4'd6);
      check("R6 sll literal", 32'(result), 32'h0002);
      run_op("R6 srl", 16'h8001, 16'h0004, 4'd7);
      run_op("R6 sal", 16'h4321, 16'h0003, 4'd8);
      run_op("R6 sar", 16'h8000, 16'h0003, 4'd9);
      check("R6 sar literal", 32'(result), 32'hF000);
      run_op("R6 sar count 15", 16'h8000, 16'h000F, 4'd9);
      run_op("R6 count zero", 16'h1357, 16'h0000, 4'd7);
   endtask

   task automatic t_rotate();
      run_op("R7 rol", 16'h8001, 16'h0001, 4'd10);
      check("R7 rol literal", 32'(result), 32'h0003);
      run_op("R7 ror", 16'h8001, 16'h0001, 4'd11);
      check("R7 ror literal", 32'(result), 32'hC000);
      run_op("R7 rol count 16", 16'hBEEF, 16'h0010, 4'd10);
      run_op("R7 ror 5", 16'h1234, 16'h0005, 4'd11);
   endtask

   task automatic t_unused();
      for (int k = 12; k < 16; k++) begin
         run_op("R8 unused code", 16'hFFFF, 16'hFFFF, 4'(k));
         check("R8 unused flags literal", 32'(flags), 32'b0001);
      end
   endtask

   task automatic t_ignore();
      logic [19:0] exp;
      exp = model(16'h0100, 16'h0200, 4'd0);
      enter(16'h0100);
      repeat (3) @(negedge clk);
      check("R2 wait-B holds", 32'(state), 32'd2);
      enter(16'h0200);
      @(negedge clk);
      data_in = 16'hFFF0;
      strobe  = 1'b1;
      @(negedge clk);
      check("R2 code captured", 32'(state), 32'd4);
      data_in = 16'h7777;
      @(negedge clk);
      strobe = 1'b0;
      check("R3 strobe in show ignored", 32'(state), 32'd1);
      check("R2 code from low bits", 32'(result), 32'(exp[15:0]));
      repeat (2) @(negedge clk);
      check("R3 result held idle", 32'(result), 32'(exp[15:0]));
   endtask

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      t_arith();
      t_logic();
      t_shift();
      t_rotate();
      t_unused();
      t_ignore();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule